// File: doc/BRIEF.md
# Single-Dword Completer Request Engine

This block sits behind a packet link layer that has already decoded incoming requests into descriptors. Each descriptor names a request type, a byte address, a length in dwords, four byte enables, one dword of write data, a tag and a requester ID. The engine checks that the request targets its single address window and carries no more than one dword. It then moves the address from the window's bus base onto a local base that software can program, and performs exactly one read or write on a 32-bit memory-mapped master port.

Writes are posted: they need no answer. Reads, zero-length reads and rejected requests each produce one completion descriptor. A read completion carries the returned dword. A zero-length read acts as a flush: its data-less successful completion waits until any write still held at the master port has been acknowledged. A rejected request gets a data-less abort completion. The engine handles one completion at a time. Only one posted write may wait at the port, and while it waits a flush or a rejected request can still be accepted behind it.

Top module: `sdw_completer`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1 and `m_read`, `m_write` and `cpl_valid` are 0.
- R2: An accepted write (type code 1, length 1, address inside the window) issues one master write. Its address is `(req_addr - BAR_BASE + cfg_local_base)` with bits 1:0 cleared. Its byte enables, including zero and non-contiguous patterns, and its data are passed on unchanged. It produces no completion.
- R3: An accepted read (type code 0, length 1, byte enables not 0000, address inside the window) issues one master read with the translated address and unchanged byte enables. It then returns a completion with status 3'b000 (successful), `cpl_has_data` = 1, `cpl_data` = the `m_rdata` captured with `m_rdvalid`, and the request's tag and requester ID.
- R4: `cpl_lower_addr` equals `{req_addr[6:2], n}`, where n is the index of the lowest set byte enable, or 0 when no byte enable is set.
- R5: While `m_read` or `m_write` is high and `m_waitreq` is high, the command stays asserted and `m_addr`, `m_be` and `m_wdata` hold their values.
- R6: A request is rejected when its type code is 2 or 3, its length is not 1 (0 stands for 1024), or its address lies outside the window of 2^WIN_BITS bytes at `BAR_BASE`. A rejected request makes no master access and gets a completion with status 3'b100 (abort) and `cpl_has_data` = 0.
- R7: A read of length 1 with byte enables 0000 is a flush. It makes no master access. Its completion has status 3'b000 and `cpl_has_data` = 0, and `cpl_valid` does not rise before every earlier write has been acknowledged (`m_write` high and `m_waitreq` low at a clock edge).
- R8: `req_ready` is low from the acceptance of a read, flush or rejected request until its completion is taken (`cpl_valid` and `cpl_ready` both high). While a write waits at the port, reads and writes are not accepted.
- R9: While `cpl_valid` is high and `cpl_ready` is low, `cpl_valid` stays high and every completion field holds its value.
- R10: `m_read` falls in the cycle after the port accepts it (`m_waitreq` low), so each read request causes exactly one accepted master read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_local_base | input | 32 | Local base added after removing the window base |
| req_valid | input | 1 | Request descriptor valid |
| req_ready | output | 1 | Request descriptor accepted this cycle when valid |
| req_type | input | 2 | 0 read, 1 write, 2 and 3 unsupported |
| req_addr | input | 32 | Request byte address on the link side |
| req_len | input | 10 | Length in dwords, 0 meaning 1024 |
| req_be | input | 4 | Byte enables of the single dword |
| req_wdata | input | 32 | Write data |
| req_tag | input | 8 | Request tag |
| req_rid | input | 16 | Requester ID |
| m_read | output | 1 | Master read command |
| m_write | output | 1 | Master write command |
| m_addr | output | 32 | Master byte address, dword aligned |
| m_be | output | 4 | Master byte enables |
| m_wdata | output | 32 | Master write data |
| m_waitreq | input | 1 | Slave stalls the current command |
| m_rdata | input | 32 | Read data |
| m_rdvalid | input | 1 | Read data valid, at least one cycle after the read is accepted |
| cpl_valid | output | 1 | Completion descriptor valid |
| cpl_ready | input | 1 | Downstream takes the completion |
| cpl_status | output | 3 | 3'b000 successful, 3'b100 abort |
| cpl_has_data | output | 1 | Completion carries one dword |
| cpl_data | output | 32 | Completion dword |
| cpl_tag | output | 8 | Echoed tag |
| cpl_rid | output | 16 | Echoed requester ID |
| cpl_lower_addr | output | 7 | Lower address field |

## Verification
Two events can fall on the same clock edge: the port acknowledging a posted write and the engine accepting a flush. The bench provokes this by holding `m_waitreq` high so that a write stays stuck at the port, then releasing the stall on the same cycle in which it presents the flush. In a second run the stall is kept long enough for a flush to sit waiting behind the write. In both runs the bench records the edge on which the write was acknowledged and the edge on which the completion first appears, and it requires the completion to come later. In the held run it also requires `cpl_valid` to stay low for the whole stall.

// File: rtl/sdw_pkg.sv
// Shared widths, encodings and types for the single-dword completer.
// Assumes a fixed 32-bit data path with four byte lanes.
package sdw_pkg;
    localparam int DW    = 32;
    localparam int BEW   = DW / 8;
    localparam int FB_W  = $clog2(BEW);
    localparam int LEN_W = 10;
    localparam int TAG_W = 8;
    localparam int RID_W = 16;
    localparam int LA_W  = 7;

    localparam logic [1:0] TYPE_RD = 2'd0;
    localparam logic [1:0] TYPE_WR = 2'd1;

    localparam logic [2:0] CPL_SC = 3'b000;
    localparam logic [2:0] CPL_CA = 3'b100;

    typedef enum logic [1:0] {
        CLS_READ,
        CLS_WRITE,
        CLS_FLUSH,
        CLS_UNSUP
    } req_class_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ISSUE,
        S_RD_DATA,
        S_FLUSH,
        S_CPL
    } ctl_state_e;
endpackage

// File: rtl/sdw_req_decode.sv
// Classifies the presented request, translates its address and forms the
// lower-address field. Purely combinational; assumes WIN_BITS < 32 and a
// window base aligned to 2^WIN_BITS.
module sdw_req_decode
    import sdw_pkg::*;
#(
    parameter logic [31:0] BAR_BASE = 32'h8000_0000,
    parameter int          WIN_BITS = 12
) (
    input  logic [1:0]       req_type,
    input  logic [DW-1:0]    req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic [BEW-1:0]   req_be,
    input  logic [DW-1:0]    local_base,
    output req_class_e       req_class,
    output logic [DW-1:0]    xlat_addr,
    output logic [LA_W-1:0]  lower_addr
);
    logic             in_window;
    logic [FB_W-1:0]  first_byte;
    logic [DW-1:0]    offset_sum;

    assign in_window  = (req_addr >> WIN_BITS) == (BAR_BASE >> WIN_BITS);
    assign offset_sum = (req_addr - BAR_BASE) + local_base;
    assign xlat_addr  = {offset_sum[DW-1:FB_W], {FB_W{1'b0}}};

    // Index of the lowest enabled byte lane, zero when none is set.
    always_comb begin
        first_byte = '0;
        for (int i = BEW - 1; i >= 0; i--) begin
            if (req_be[i]) first_byte = FB_W'(i);
        end
    end

    assign lower_addr = {req_addr[LA_W-1:FB_W], first_byte};

    // Sort the request into read, write, flush or rejected.
    always_comb begin
        if (req_len != LEN_W'(1) || !in_window) begin
            req_class = CLS_UNSUP;
        end else if (req_type == TYPE_RD) begin
            req_class = (req_be == '0) ? CLS_FLUSH : CLS_READ;
        end else if (req_type == TYPE_WR) begin
            req_class = CLS_WRITE;
        end else begin
            req_class = CLS_UNSUP;
        end
    end
endmodule

// File: rtl/sdw_master_port.sv
// Holds the single command register that drives the 32-bit master port.
// A load arrives only when the port is idle; the command drops on the first
// edge at which the slave does not stall it.
module sdw_master_port
    import sdw_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_load,
    input  logic           wr_load,
    input  logic [DW-1:0]  ld_addr,
    input  logic [BEW-1:0] ld_be,
    input  logic [DW-1:0]  ld_wdata,
    input  logic           m_waitreq,
    output logic           m_read,
    output logic           m_write,
    output logic [DW-1:0]  m_addr,
    output logic [BEW-1:0] m_be,
    output logic [DW-1:0]  m_wdata,
    output logic           port_busy,
    output logic           wr_busy,
    output logic           rd_done
);
    // Command flags: set on load, cleared once the slave takes the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_read  <= 1'b0;
            m_write <= 1'b0;
        end else if (rd_load || wr_load) begin
            m_read  <= rd_load;
            m_write <= wr_load;
        end else if (!m_waitreq) begin
            m_read  <= 1'b0;
            m_write <= 1'b0;
        end
    end

    // Command payload: captured on load only, so it holds through stalls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_addr  <= '0;
            m_be    <= '0;
            m_wdata <= '0;
        end else if (rd_load || wr_load) begin
            m_addr  <= ld_addr;
            m_be    <= ld_be;
            m_wdata <= ld_wdata;
        end
    end

    assign port_busy = m_read | m_write;
    assign wr_busy   = m_write;
    assign rd_done   = m_read & ~m_waitreq;

    a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (m_read || m_write) && m_waitreq |=>
            (m_read || m_write) && $stable(m_addr) && $stable(m_be) && $stable(m_wdata));

    a_r10_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        m_read && !m_waitreq |=> !m_read);

    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_read && m_write));
endmodule

// File: rtl/sdw_cpl_ctrl.sv
// Sequences one request at a time and owns the completion descriptor.
// Assumes read data returns at least one cycle after the read is accepted.
module sdw_cpl_ctrl
    import sdw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  req_class_e       req_class,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [RID_W-1:0] req_rid,
    input  logic [LA_W-1:0]  lower_addr,
    input  logic             port_busy,
    input  logic             wr_busy,
    input  logic             rd_done,
    input  logic             m_rdvalid,
    input  logic [DW-1:0]    m_rdata,
    input  logic             cpl_ready,
    output logic             req_ready,
    output logic             rd_load,
    output logic             wr_load,
    output logic             cpl_valid,
    output logic [2:0]       cpl_status,
    output logic             cpl_has_data,
    output logic [DW-1:0]    cpl_data,
    output logic [TAG_W-1:0] cpl_tag,
    output logic [RID_W-1:0] cpl_rid,
    output logic [LA_W-1:0]  cpl_lower_addr
);
    ctl_state_e state;
    logic       needs_port;
    logic       accept;

    assign needs_port = (req_class == CLS_READ) || (req_class == CLS_WRITE);
    assign req_ready  = (state == S_IDLE) && !(port_busy && needs_port);
    assign accept     = req_valid && req_ready;
    assign rd_load    = accept && (req_class == CLS_READ);
    assign wr_load    = accept && (req_class == CLS_WRITE);
    assign cpl_valid  = (state == S_CPL);

    // Request sequencer: one read, flush or rejection in flight at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: if (accept) begin
                    unique case (req_class)
                        CLS_READ:  state <= S_RD_ISSUE;
                        CLS_WRITE: state <= S_IDLE;
                        CLS_FLUSH: state <= S_FLUSH;
                        default:   state <= S_CPL;
                    endcase
                end
                S_RD_ISSUE: if (rd_done)   state <= S_RD_DATA;
                S_RD_DATA:  if (m_rdvalid) state <= S_CPL;
                S_FLUSH:    if (!wr_busy)  state <= S_CPL;
                S_CPL:      if (cpl_ready) state <= S_IDLE;
                default:    state <= S_IDLE;
            endcase
        end
    end

    // Completion header fields, captured when a non-write request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpl_status     <= CPL_SC;
            cpl_has_data   <= 1'b0;
            cpl_tag        <= '0;
            cpl_rid        <= '0;
            cpl_lower_addr <= '0;
        end else if (accept && req_class != CLS_WRITE) begin
            cpl_status     <= (req_class == CLS_UNSUP) ? CPL_CA : CPL_SC;
            cpl_has_data   <= (req_class == CLS_READ);
            cpl_tag        <= req_tag;
            cpl_rid        <= req_rid;
            cpl_lower_addr <= lower_addr;
        end
    end

    // Completion payload, captured when the read data returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpl_data <= '0;
        end else if (state == S_RD_DATA && m_rdvalid) begin
            cpl_data <= m_rdata;
        end
    end

    a_r9_cpl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid && !cpl_ready |=>
            cpl_valid && $stable(cpl_status) && $stable(cpl_has_data) &&
            $stable(cpl_data) && $stable(cpl_tag) && $stable(cpl_rid) &&
            $stable(cpl_lower_addr));
endmodule

// File: rtl/sdw_completer.sv
// Single-dword completer: decodes request descriptors, performs one access
// on a 32-bit master port with window translation, and returns completions
// for reads, flushes and rejected requests. Writes are posted.
module sdw_completer
    import sdw_pkg::*;
#(
    parameter logic [31:0] BAR_BASE = 32'h8000_0000,
    parameter int          WIN_BITS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      cfg_local_base,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_type,
    input  logic [31:0]      req_addr,
    input  logic [9:0]       req_len,
    input  logic [3:0]       req_be,
    input  logic [31:0]      req_wdata,
    input  logic [7:0]       req_tag,
    input  logic [15:0]      req_rid,
    output logic             m_read,
    output logic             m_write,
    output logic [31:0]      m_addr,
    output logic [3:0]       m_be,
    output logic [31:0]      m_wdata,
    input  logic             m_waitreq,
    input  logic [31:0]      m_rdata,
    input  logic             m_rdvalid,
    output logic             cpl_valid,
    input  logic             cpl_ready,
    output logic [2:0]       cpl_status,
    output logic             cpl_has_data,
    output logic [31:0]      cpl_data,
    output logic [7:0]       cpl_tag,
    output logic [15:0]      cpl_rid,
    output logic [6:0]       cpl_lower_addr
);
    req_class_e        req_class;
    logic [DW-1:0]     xlat_addr;
    logic [LA_W-1:0]   lower_addr;
    logic              rd_load;
    logic              wr_load;
    logic              port_busy;
    logic              wr_busy;
    logic              rd_done;

    sdw_req_decode #(
        .BAR_BASE (BAR_BASE),
        .WIN_BITS (WIN_BITS)
    ) u_decode (
        .req_type   (req_type),
        .req_addr   (req_addr),
        .req_len    (req_len),
        .req_be     (req_be),
        .local_base (cfg_local_base),
        .req_class  (req_class),
        .xlat_addr  (xlat_addr),
        .lower_addr (lower_addr)
    );

    sdw_master_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_load   (rd_load),
        .wr_load   (wr_load),
        .ld_addr   (xlat_addr),
        .ld_be     (req_be),
        .ld_wdata  (req_wdata),
        .m_waitreq (m_waitreq),
        .m_read    (m_read),
        .m_write   (m_write),
        .m_addr    (m_addr),
        .m_be      (m_be),
        .m_wdata   (m_wdata),
        .port_busy (port_busy),
        .wr_busy   (wr_busy),
        .rd_done   (rd_done)
    );

    sdw_cpl_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_class      (req_class),
        .req_tag        (req_tag),
        .req_rid        (req_rid),
        .lower_addr     (lower_addr),
        .port_busy      (port_busy),
        .wr_busy        (wr_busy),
        .rd_done        (rd_done),
        .m_rdvalid      (m_rdvalid),
        .m_rdata        (m_rdata),
        .cpl_ready      (cpl_ready),
        .req_ready      (req_ready),
        .rd_load        (rd_load),
        .wr_load        (wr_load),
        .cpl_valid      (cpl_valid),
        .cpl_status     (cpl_status),
        .cpl_has_data   (cpl_has_data),
        .cpl_data       (cpl_data),
        .cpl_tag        (cpl_tag),
        .cpl_rid        (cpl_rid),
        .cpl_lower_addr (cpl_lower_addr)
    );

    a_r3_data_from_port: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpl_valid) && cpl_has_data |-> $past(m_rdvalid));

    a_r6_abort_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid && cpl_status == CPL_CA |-> !cpl_has_data && !m_read);

    a_r7_flush_drained: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid && cpl_status == CPL_SC && !cpl_has_data |-> !m_write);
endmodule

// File: tb/sdw_completer_bench.sv
`timescale 1ns/1ps
module sdw_completer_bench;
    localparam logic [31:0] BAR = 32'h8000_0000;
    localparam int          WB  = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_local_base = 32'h0001_0000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_type = '0;
    logic [31:0] req_addr = '0;
    logic [9:0]  req_len = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic [7:0]  req_tag = '0;
    logic [15:0] req_rid = '0;
    logic        m_read, m_write;
    logic [31:0] m_addr, m_wdata;
    logic [3:0]  m_be;
    logic        m_waitreq = 1'b0;
    logic [31:0] m_rdata = '0;
    logic        m_rdvalid = 1'b0;
    logic        cpl_valid;
    logic        cpl_ready = 1'b0;
    logic [2:0]  cpl_status;
    logic        cpl_has_data;
    logic [31:0] cpl_data;
    logic [7:0]  cpl_tag;
    logic [15:0] cpl_rid;
    logic [6:0]  cpl_lower_addr;

    sdw_completer #(.BAR_BASE(BAR), .WIN_BITS(WB)) u_sdw_completer (.*);

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    // slave model state
    bit          force_stall = 0;
    bit          stall_rand = 0;
    bit          cpl_bp = 0;
    int          nwr = 0, nrd = 0;
    int          wr_ack_edge = -1;
    int          cpl_seen = -1;
    logic [31:0] lw_addr, lw_data, lr_addr;
    logic [3:0]  lw_be, lr_be;
    bit          rd_pend = 0;
    int          rd_dly = 0;
    logic [31:0] rd_a;
    bit          prev_stall = 0;
    logic [31:0] prev_addr, prev_wdata;
    logic [3:0]  prev_be;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] rd_model(input logic [31:0] a);
        return (a * 32'h0001_0003) ^ 32'hC0DE_5A5A;
    endfunction

    function automatic logic [31:0] xlat(input logic [31:0] a, input logic [31:0] lb);
        return ((a - BAR) + lb) & ~32'h3;
    endfunction

    function automatic logic [6:0] exp_la(input logic [31:0] a, input logic [3:0] be);
        logic [1:0] n = 2'd0;
        for (int i = 3; i >= 0; i--) if (be[i]) n = 2'(i);
        return {a[6:2], n};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Slave: stalls, read data return, access logging, R5 hold check.
    always @(negedge clk) begin
        m_rdvalid = 1'b0;
        if (rd_pend) begin
            if (rd_dly == 0) begin
                m_rdvalid = 1'b1;
                m_rdata = rd_model(rd_a);
                rd_pend = 0;
            end else rd_dly--;
        end
        if (prev_stall && rst_n)
            chk((m_read || m_write) && m_addr == prev_addr && m_be == prev_be && m_wdata == prev_wdata,
                "R5 hold under stall", {m_addr, m_wdata}, {prev_addr, prev_wdata});
        m_waitreq = force_stall | (stall_rand && ($urandom % 3 == 0));
        prev_stall = (m_read || m_write) && m_waitreq;
        prev_addr = m_addr; prev_be = m_be; prev_wdata = m_wdata;
        if (m_read && !m_waitreq) begin
            nrd++; lr_addr = m_addr; lr_be = m_be;
            rd_pend = 1; rd_dly = $urandom % 3; rd_a = m_addr;
        end
        if (m_write && !m_waitreq) begin
            nwr++; lw_addr = m_addr; lw_be = m_be; lw_data = m_wdata;
            wr_ack_edge = cyc + 1;
        end
    end

    // Present a request at a negedge and hold it until accepted.
    task automatic send(input logic [1:0] t, input logic [31:0] a, input logic [9:0] l,
                        input logic [3:0] be, input logic [31:0] d, input logic [7:0] tg,
                        input logic [15:0] rid);
        bit acc;
        req_valid = 1; req_type = t; req_addr = a; req_len = l; req_be = be;
        req_wdata = d; req_tag = tg; req_rid = rid;
        forever begin
            #1 acc = req_ready;
            @(posedge clk);
            if (acc) break;
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic get_cpl(input logic [2:0] est, input logic ed, input logic [31:0] edata,
                           input logic [7:0] etag, input logic [15:0] erid, input logic [6:0] ela,
                           input string rq);
        int w = 0;
        int holds;
        logic [63:0] snap;
        while (!cpl_valid && w < 2000) begin @(negedge clk); w++; end
        if (!cpl_valid) begin chk(0, {rq, " completion missing"}, 0, 1); return; end
        cpl_seen = cyc;
        chk(req_ready == 0, "R8 ready low while completion pending", req_ready, 0);
        holds = cpl_bp ? ($urandom % 3) : 0;
        snap = {cpl_status, cpl_has_data, cpl_lower_addr, cpl_tag, cpl_rid, 29'd0};
        for (int h = 0; h < holds; h++) begin
            @(negedge clk);
            chk(cpl_valid && {cpl_status, cpl_has_data, cpl_lower_addr, cpl_tag, cpl_rid, 29'd0} == snap,
                "R9 completion held", {cpl_status, cpl_has_data, cpl_lower_addr, cpl_tag, cpl_rid, 29'd0}, snap);
        end
        chk(cpl_status == est && cpl_has_data == ed, {rq, " status/data flag"},
            {cpl_status, cpl_has_data}, {est, ed});
        chk(cpl_tag == etag && cpl_rid == erid, {rq, " tag/rid echo"}, {cpl_tag, cpl_rid}, {etag, erid});
        chk(cpl_lower_addr == ela, "R4 lower address", cpl_lower_addr, ela);
        if (ed) chk(cpl_data == edata, "R3 read data", cpl_data, edata);
        cpl_ready = 1;
        @(negedge clk);
        cpl_ready = 0;
        chk(cpl_valid == 0, "R8 completion retired", cpl_valid, 0);
    endtask

    task automatic do_write(input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
        int n0 = nwr;
        int w = 0;
        send(2'd1, a, 10'd1, be, d, 8'h00, 16'h0000);
        while (nwr == n0 && w < 500) begin @(negedge clk); #1; w++; end
        chk(nwr == n0 + 1, "R2 one write issued", nwr - n0, 1);
        chk(lw_addr == xlat(a, cfg_local_base) && lw_be == be && lw_data == d, "R2 write fields",
            {lw_addr, lw_data}, {xlat(a, cfg_local_base), d});
        chk(cpl_valid == 0, "R2 no write completion", cpl_valid, 0);
    endtask

    task automatic do_read(input logic [31:0] a, input logic [3:0] be, input logic [7:0] tg,
                           input logic [15:0] rid);
        int n0 = nrd;
        logic [31:0] xa = xlat(a, cfg_local_base);
        send(2'd0, a, 10'd1, be, 32'hDEAD_BEEF, tg, rid);
        get_cpl(3'b000, 1'b1, rd_model(xa), tg, rid, exp_la(a, be), "R3 read");
        chk(nrd == n0 + 1, "R10 exactly one master read", nrd - n0, 1);
        chk(lr_addr == xa && lr_be == be, "R3 read address/be", {lr_addr, 28'd0, lr_be}, {xa, 28'd0, be});
    endtask

    task automatic do_unsup(input logic [1:0] t, input logic [31:0] a, input logic [9:0] l,
                            input logic [3:0] be, input logic [7:0] tg);
        int r0 = nrd, w0 = nwr;
        send(t, a, l, be, 32'h1111_2222, tg, 16'hBEEF);
        get_cpl(3'b100, 1'b0, 0, tg, 16'hBEEF, exp_la(a, be), "R6 abort");
        chk(nrd == r0 && nwr == w0, "R6 no master access", nrd + nwr, r0 + w0);
    endtask

    task automatic do_flush(input logic [31:0] a, input logic [7:0] tg);
        int r0 = nrd, w0 = nwr;
        send(2'd0, a, 10'd1, 4'h0, 0, tg, 16'h0F0F);
        get_cpl(3'b000, 1'b0, 0, tg, 16'h0F0F, exp_la(a, 4'h0), "R7 flush");
        chk(nrd == r0 && nwr == w0, "R7 flush no master access", nrd + nwr, r0 + w0);
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cyc == 150000 && !done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1 && m_read == 0 && m_write == 0 && cpl_valid == 0, "R1 reset state",
            {req_ready, m_read, m_write, cpl_valid}, 4'b1000);

        // Directed: basic write and read, non-contiguous and empty enables
        do_write(BAR + 32'h124, 4'b1001, 32'hA1B2_C3D4);
        do_write(BAR + 32'h7, 4'b0000, 32'h0000_0055);
        do_read(BAR + 32'h124, 4'b1010, 8'h11, 16'h0102);
        do_read(BAR + 32'hFFC, 4'b1000, 8'h12, 16'h0304);
        do_read(BAR + 32'h040, 4'b0101, 8'h13, 16'h0506);

        // Directed rejections
        do_unsup(2'd2, BAR + 32'h10, 10'd1, 4'hF, 8'h21);
        do_unsup(2'd3, BAR + 32'h10, 10'd1, 4'hF, 8'h22);
        do_unsup(2'd0, BAR + 32'h10, 10'd2, 4'hF, 8'h23);
        do_unsup(2'd1, BAR + 32'h10, 10'd0, 4'hF, 8'h24);
        do_unsup(2'd0, BAR + 32'h1000, 10'd1, 4'h2, 8'h25);
        do_unsup(2'd1, BAR - 32'h4, 10'd1, 4'hF, 8'h26);

        // Flush with nothing pending
        do_flush(BAR + 32'h88, 8'h31);

        // Flush held behind a stalled write; reads blocked meanwhile
        force_stall = 1;
        send(2'd1, BAR + 32'h200, 10'd1, 4'hF, 32'h5555_AAAA, 8'h0, 16'h0);
        req_valid = 1; req_type = 2'd0; req_addr = BAR + 32'h204; req_len = 10'd1; req_be = 4'hF;
        #1 chk(req_ready == 0, "R8 read blocked by pending write", req_ready, 0);
        req_valid = 0;
        @(negedge clk);
        send(2'd0, BAR + 32'h208, 10'd1, 4'h0, 0, 8'h32, 16'h7777);
        for (int k = 0; k < 6; k++) begin
            chk(cpl_valid == 0, "R7 flush waits for write", cpl_valid, 0);
            @(negedge clk);
        end
        @(posedge clk); #1 force_stall = 0;
        get_cpl(3'b000, 1'b0, 0, 8'h32, 16'h7777, exp_la(BAR + 32'h208, 4'h0), "R7 held flush");
        chk(wr_ack_edge < cpl_seen, "R7 completion after write ack", wr_ack_edge, cpl_seen);

        // Flush accepted on the very edge the stalled write is acknowledged
        force_stall = 1;
        send(2'd1, BAR + 32'h300, 10'd1, 4'h6, 32'h0BAD_F00D, 8'h0, 16'h0);
        repeat (3) @(negedge clk);
        @(posedge clk); #1 force_stall = 0;
        @(negedge clk);
        send(2'd0, BAR + 32'h30C, 10'd1, 4'h0, 0, 8'h33, 16'h8888);
        get_cpl(3'b000, 1'b0, 0, 8'h33, 16'h8888, exp_la(BAR + 32'h30C, 4'h0), "R7 same-edge flush");
        chk(wr_ack_edge < cpl_seen, "R7 same-edge ordering", wr_ack_edge, cpl_seen);
        chk(lw_addr == xlat(BAR + 32'h300, cfg_local_base) && lw_be == 4'h6, "R2 stalled write fields",
            lw_addr, xlat(BAR + 32'h300, cfg_local_base));

        // Random mix with port stalls and completion backpressure
        stall_rand = 1; cpl_bp = 1;
        for (int it = 0; it < 300; it++) begin
            int kind = $urandom % 8;
            logic [31:0] a = BAR + ($urandom % 4096);
            logic [7:0]  tg = 8'($urandom);
            if (it == 150) cfg_local_base = 32'h2000_0400;
            if (kind < 3) do_write(a, 4'($urandom), $urandom);
            else if (kind < 6) do_read(a, 4'(1 + $urandom % 15), tg, 16'($urandom));
            else if (kind == 6) begin
                case ($urandom % 3)
                    0: do_unsup(2'(2 + $urandom % 2), a, 10'd1, 4'($urandom), tg);
                    1: do_unsup(2'($urandom % 2), a, 10'(2 + $urandom % 500), 4'($urandom), tg);
                    default: do_unsup(2'($urandom % 2), a + 32'h0100_0000, 10'd1, 4'($urandom), tg);
                endcase
            end else do_flush(a, tg);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule